// File: doc/BRIEF.md
# Bounded-Occupancy Weight Block Codec

This block compresses signed byte weights in groups of eight consecutive elements along the reduction dimension. Each group may hold at most a fixed number of non-zero entries (four by default). The encoder turns each group into a fixed-size record. The record holds an occupancy byte with one bit per element, the surviving non-zero values packed into a fixed number of value slots, and a small position index per slot that a multiplexed datapath can use directly. Because the record size is fixed, a group of eight bytes shrinks to five bytes of stored data: the occupancy byte plus four values. The indices are derived from the occupancy byte and need not be stored.

A group that holds more non-zero entries than the bound allows is flagged. Its lowest-index entries are kept, up to the bound, and the occupancy byte describes only those kept entries.

The decoder rebuilds the dense group from the occupancy byte and the value slots. Both halves are streaming stages with valid/ready handshakes on each side, one group per cycle and one register of latency. They can be chained so that the encoder feeds the decoder directly, or used on their own.

Top module: `dbb_codec`

## Requirements
- R1: Bit i of `enc_out_mask` is set exactly when byte i of `enc_in_data` (bits 8i+7..8i) is non-zero, for every group with no more than four non-zero bytes.
- R2: Non-zero bytes are packed in ascending element position: slot s (bits 8s+7..8s of `enc_out_vals`) holds the s-th non-zero byte counted from element 0.
- R3: Slots beyond the last packed value carry value 0 and index 0.
- R4: Field s of `enc_out_idx` (bits 3s+2..3s) holds the element position, 0 to 7, of the value in slot s.
- R5: `enc_out_viol` is 1 exactly when the group has more than four non-zero bytes. In that case only the four lowest-position non-zero bytes are packed, and the mask shows only those four.
- R6: The decoder output places slot values at the positions of the set mask bits in ascending order and zeros elsewhere. An encode followed by a decode reproduces any bounded group exactly.
- R7: Each stage presents a group on its output in the cycle after it is accepted. With the output side ready, it accepts a new group every cycle.
- R8: While an output is valid and not ready, its data stays unchanged. Across any pattern of backpressure, every accepted group appears exactly once, in order.
- R9: After reset both output valids are 0 and both input readies are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_vld | input | 1 | Dense group offered to encoder |
| enc_in_rdy | output | 1 | Encoder can accept a group |
| enc_in_data | input | 64 | Dense group, byte i = element i |
| enc_out_vld | output | 1 | Compressed record valid |
| enc_out_rdy | input | 1 | Consumer takes the compressed record |
| enc_out_mask | output | 8 | Occupancy bits of kept elements |
| enc_out_vals | output | 32 | Packed value slots |
| enc_out_idx | output | 12 | Element position per slot |
| enc_out_viol | output | 1 | Group exceeded the non-zero bound |
| dec_in_vld | input | 1 | Compressed record offered to decoder |
| dec_in_rdy | output | 1 | Decoder can accept a record |
| dec_in_mask | input | 8 | Occupancy bits |
| dec_in_vals | input | 32 | Packed value slots |
| dec_out_vld | output | 1 | Dense group valid |
| dec_out_rdy | input | 1 | Consumer takes the dense group |
| dec_out_data | output | 64 | Rebuilt dense group |

## Verification
Every cycle, the assertions check the handshake rules: a stalled output holds its data, an accepted group shows up on the next cycle, and the record stays self-consistent. A flagged record must carry a full mask, and slots past the mask population must be zero. Whether values land in the right slots, whether indices match positions, and whether decode inverts encode can only be shown by the scoreboard. The scoreboard compares each record and each rebuilt group against a model derived from the requirements, under random backpressure and with directed groups at the bound, over the bound, all zero and with extreme byte values.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
    parameter int BLK = 8;
    parameter int EW  = 8;
    parameter int NZ  = 4;

    localparam int IW      = $clog2(BLK);
    localparam int DENSE_W = BLK * EW;
    localparam int VAL_W   = NZ * EW;
    localparam int IDX_W   = NZ * IW;

    typedef struct packed {
        logic             viol;
        logic [IDX_W-1:0] idx;
        logic [VAL_W-1:0] vals;
        logic [BLK-1:0]   mask;
    } cmp_t;

    localparam int CMP_W = $bits(cmp_t);
endpackage

// File: rtl/dbb_pack.sv
module dbb_pack
    import dbb_pkg::*;
(
    input  logic [DENSE_W-1:0] dense_i,
    output cmp_t               cmp_o
);
    cmp_t res_d;
    int   kept_d;
    int   seen_d;

    always_comb begin
        res_d  = '0;
        kept_d = 0;
        seen_d = 0;
        for (int i = 0; i < BLK; i++) begin
            if (dense_i[i*EW +: EW] != '0) begin
                seen_d = seen_d + 1;
                if (kept_d < NZ) begin
                    res_d.vals[kept_d*EW +: EW] = dense_i[i*EW +: EW];
                    res_d.idx[kept_d*IW +: IW]  = IW'(i);
                    res_d.mask[i]               = 1'b1;
                    kept_d                      = kept_d + 1;
                end
            end
        end
        res_d.viol = (seen_d > NZ);
    end

    assign cmp_o = res_d;
endmodule

// File: rtl/dbb_unpack.sv
module dbb_unpack
    import dbb_pkg::*;
(
    input  logic [BLK-1:0]     mask_i,
    input  logic [VAL_W-1:0]   vals_i,
    output logic [DENSE_W-1:0] dense_o
);
    logic [DENSE_W-1:0] dense_d;
    int                 slot_d;

    always_comb begin
        dense_d = '0;
        slot_d  = 0;
        for (int i = 0; i < BLK; i++) begin
            if (mask_i[i] && slot_d < NZ) begin
                dense_d[i*EW +: EW] = vals_i[slot_d*EW +: EW];
                slot_d              = slot_d + 1;
            end
        end
    end

    assign dense_o = dense_d;
endmodule

// File: rtl/dbb_stage.sv
module dbb_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    output logic         in_rdy,
    input  logic [W-1:0] in_data,
    output logic         out_vld,
    input  logic         out_rdy,
    output logic [W-1:0] out_data
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] data;
    } st_t;

    st_t st_d, st_q;
    logic take;

    assign in_rdy = !st_q.vld || out_rdy;
    assign take   = in_vld && in_rdy;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.vld  = 1'b1;
            st_d.data = in_data;
        end else if (out_rdy) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign out_data = st_q.data;

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && !out_rdy |=> out_vld && $stable(out_data));

    // R7
    accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && in_rdy |=> out_vld && out_data == $past(in_data));
endmodule

// File: rtl/dbb_codec.sv
module dbb_codec
    import dbb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enc_in_vld,
    output logic               enc_in_rdy,
    input  logic [DENSE_W-1:0] enc_in_data,
    output logic               enc_out_vld,
    input  logic               enc_out_rdy,
    output logic [BLK-1:0]     enc_out_mask,
    output logic [VAL_W-1:0]   enc_out_vals,
    output logic [IDX_W-1:0]   enc_out_idx,
    output logic               enc_out_viol,
    input  logic               dec_in_vld,
    output logic               dec_in_rdy,
    input  logic [BLK-1:0]     dec_in_mask,
    input  logic [VAL_W-1:0]   dec_in_vals,
    output logic               dec_out_vld,
    input  logic               dec_out_rdy,
    output logic [DENSE_W-1:0] dec_out_data
);
    cmp_t               enc_cmp;
    cmp_t               enc_reg;
    logic [DENSE_W-1:0] dec_dense;

    dbb_pack u_pack (
        .dense_i (enc_in_data),
        .cmp_o   (enc_cmp)
    );

    dbb_stage #(.W(CMP_W)) u_enc_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (enc_in_vld),
        .in_rdy   (enc_in_rdy),
        .in_data  (enc_cmp),
        .out_vld  (enc_out_vld),
        .out_rdy  (enc_out_rdy),
        .out_data (enc_reg)
    );

    assign enc_out_mask = enc_reg.mask;
    assign enc_out_vals = enc_reg.vals;
    assign enc_out_idx  = enc_reg.idx;
    assign enc_out_viol = enc_reg.viol;

    dbb_unpack u_unpack (
        .mask_i  (dec_in_mask),
        .vals_i  (dec_in_vals),
        .dense_o (dec_dense)
    );

    dbb_stage #(.W(DENSE_W)) u_dec_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (dec_in_vld),
        .in_rdy   (dec_in_rdy),
        .in_data  (dec_dense),
        .out_vld  (dec_out_vld),
        .out_rdy  (dec_out_rdy),
        .out_data (dec_out_data)
    );

    // R5
    viol_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_out_vld && enc_out_viol |-> $countones(enc_out_mask) == NZ);

    // R1
    mask_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_out_vld |-> $countones(enc_out_mask) <= NZ);

    generate
        for (genvar s = 0; s < NZ; s++) begin : g_slot
            // R3
            pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                enc_out_vld && $countones(enc_out_mask) <= s
                |-> enc_out_vals[s*EW +: EW] == '0 && enc_out_idx[s*IW +: IW] == '0);
        end
    endgenerate
endmodule

// File: tb/dbb_codec_bench.sv
module dbb_codec_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_in_vld = 1'b0;
    logic        enc_in_rdy;
    logic [63:0] enc_in_data = '0;
    logic        enc_out_vld;
    logic [7:0]  enc_out_mask;
    logic [31:0] enc_out_vals;
    logic [11:0] enc_out_idx;
    logic        enc_out_viol;
    logic        dec_in_rdy;
    logic        dec_out_vld;
    logic        dec_out_rdy = 1'b1;
    logic [63:0] dec_out_data;

    int checks = 0;
    int failures = 0;
    bit bp_en = 1'b0;
    bit done = 1'b0;

    logic [52:0] cmp_q[$];
    logic [63:0] dense_q[$];

    always #2.5 clk = ~clk;

    dbb_codec u_dbb_codec (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_in_vld   (enc_in_vld),
        .enc_in_rdy   (enc_in_rdy),
        .enc_in_data  (enc_in_data),
        .enc_out_vld  (enc_out_vld),
        .enc_out_rdy  (dec_in_rdy),
        .enc_out_mask (enc_out_mask),
        .enc_out_vals (enc_out_vals),
        .enc_out_idx  (enc_out_idx),
        .enc_out_viol (enc_out_viol),
        .dec_in_vld   (enc_out_vld),
        .dec_in_rdy   (dec_in_rdy),
        .dec_in_mask  (enc_out_mask),
        .dec_in_vals  (enc_out_vals),
        .dec_out_vld  (dec_out_vld),
        .dec_out_rdy  (dec_out_rdy),
        .dec_out_data (dec_out_data)
    );

    // Expected record {viol, idx, vals, mask} from R1..R5
    function automatic logic [52:0] model_cmp(input logic [63:0] d);
        logic [7:0]  m = '0;
        logic [31:0] v = '0;
        logic [11:0] x = '0;
        int n = 0;
        int k = 0;
        for (int i = 0; i < 8; i++) begin
            if (d[i*8 +: 8] != 8'h00) begin
                n++;
                if (k < 4) begin
                    m[i] = 1'b1;
                    v[k*8 +: 8] = d[i*8 +: 8];
                    x[k*3 +: 3] = 3'(i);
                    k++;
                end
            end
        end
        return {(n > 4), x, v, m};
    endfunction

    // Expected dense output from R6
    function automatic logic [63:0] model_dense(input logic [63:0] d);
        logic [63:0] r = '0;
        int k = 0;
        for (int i = 0; i < 8; i++) begin
            if (d[i*8 +: 8] != 8'h00 && k < 4) begin
                r[i*8 +: 8] = d[i*8 +: 8];
                k++;
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] d);
        forever begin
            @(negedge clk);
            enc_in_vld  = 1'b1;
            enc_in_data = d;
            #1;
            if (enc_in_rdy) begin
                cmp_q.push_back(model_cmp(d));
                dense_q.push_back(model_dense(d));
                @(posedge clk);
                break;
            end
            @(posedge clk);
        end
        @(negedge clk);
        enc_in_vld = 1'b0;
    endtask

    function automatic logic [63:0] rand_block(input int limit);
        logic [63:0] d = '0;
        int n = 0;
        for (int i = 0; i < 8; i++) begin
            if (($urandom % 2) == 0 && n < limit) begin
                d[i*8 +: 8] = 8'($urandom_range(1, 255));
                n++;
            end
        end
        return d;
    endfunction

    // backpressure on the dense output
    always @(negedge clk) begin
        if (bp_en) dec_out_rdy = (($urandom % 3) != 0);
        else       dec_out_rdy = 1'b1;
    end

    // scoreboard monitor
    bit          stall_seen = 1'b0;
    logic [63:0] stall_data = '0;
    always @(negedge clk) begin
        #1.5;
        if (rst_n) begin
            if (enc_out_vld && dec_in_rdy) begin
                logic [52:0] got;
                logic [52:0] exp;
                got = {enc_out_viol, enc_out_idx, enc_out_vals, enc_out_mask};
                if (cmp_q.size() == 0) begin
                    check(1'b0, "R8 extra record", 64'(got), 64'h0);
                end else begin
                    exp = cmp_q.pop_front();
                    // R1 mask, R2 packing order, R3 padding
                    check(got[39:0] == exp[39:0], "R1/R2/R3 mask+vals", 64'(got[39:0]), 64'(exp[39:0]));
                    // R4 slot indices
                    check(got[51:40] == exp[51:40], "R4 idx", 64'(got[51:40]), 64'(exp[51:40]));
                    // R5 violation flag
                    check(got[52] == exp[52], "R5 viol", 64'(got[52]), 64'(exp[52]));
                end
            end
            if (stall_seen && dec_out_vld) begin
                // R8 held data while stalled
                check(dec_out_data == stall_data, "R8 stall hold", dec_out_data, stall_data);
            end
            if (dec_out_vld && dec_out_rdy) begin
                if (dense_q.size() == 0) begin
                    check(1'b0, "R8 extra group", dec_out_data, 64'h0);
                end else begin
                    logic [63:0] e;
                    e = dense_q.pop_front();
                    // R6 round trip
                    check(dec_out_data == e, "R6 decode", dec_out_data, e);
                end
            end
            stall_seen = dec_out_vld && !dec_out_rdy;
            stall_data = dec_out_data;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R7 watchdog actual=hung expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        check(!enc_out_vld && !dec_out_vld, "R9 out valids", 64'({enc_out_vld, dec_out_vld}), 64'h0);
        check(enc_in_rdy && dec_in_rdy, "R9 in readies", 64'({enc_in_rdy, dec_in_rdy}), 64'h3);

        // R7 latency on an empty pipeline
        send(64'h0000_0011_0000_0022);
        #1;
        check(enc_out_vld == 1'b1, "R7 enc latency", 64'(enc_out_vld), 64'h1);
        @(negedge clk);
        #1;
        check(dec_out_vld == 1'b1, "R7 dec latency", 64'(dec_out_vld), 64'h1);
        repeat (3) @(posedge clk);

        // directed corners: zero, full bound, over bound, extremes, ends
        send(64'h0);                         // R3 all slots padded
        send(64'h0000_0000_0400_0302 | 64'h0100_0000_0000_0000); // R2 R4 four at bound
        send(64'h8801_7F02_8003_FF04);       // R5 all eight non-zero
        send(64'h0000_0005_0400_0302 | 64'h0100_0000_0000_0000); // R5 five non-zero
        send(64'h8000_0000_0000_007F);       // R1 ends with extreme values
        send(64'hFF00_0000_0000_0000);       // R4 top position only

        // R7 back-to-back throughput with no backpressure
        for (int n = 0; n < 20; n++) begin
            logic [63:0] d;
            d = rand_block(4);
            @(negedge clk);
            enc_in_vld  = 1'b1;
            enc_in_data = d;
            #1;
            check(enc_in_rdy == 1'b1, "R7 full rate", 64'(enc_in_rdy), 64'h1);
            cmp_q.push_back(model_cmp(d));
            dense_q.push_back(model_dense(d));
            @(posedge clk);
        end
        @(negedge clk);
        enc_in_vld = 1'b0;

        // random bounded groups under backpressure
        bp_en = 1'b1;
        for (int n = 0; n < 300; n++) send(rand_block(4));
        // random groups that may break the bound
        for (int n = 0; n < 100; n++) send(rand_block(8));
        bp_en = 1'b0;

        for (int n = 0; n < 200 && (cmp_q.size() != 0 || dense_q.size() != 0); n++) @(posedge clk);
        // R8 nothing dropped
        check(cmp_q.size() == 0, "R8 records drained", 64'(cmp_q.size()), 64'h0);
        check(dense_q.size() == 0, "R8 groups drained", 64'(dense_q.size()), 64'h0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule